// File: doc/BRIEF.md
# Mode-Selectable Clock Divider with Gated Fan-out

This block drives four clock outputs from one input clock. A two-bit mode input picks the source. In pass-through mode the input clock goes straight to the outputs. In divide mode a counter produces a slower clock whose period is the divide code plus one input cycles. A divide code of zero falls back to pass-through. The two mode values that are not defined raise an error flag and hold every output low.

The divider restarts from a known phase in two ways: a software restart level, or a one-cycle sync strobe that counts only while its qualifier input is high. While a restart is held, the divided clock stays low. Its first rising edge comes at the first input edge after the restart is released. Each output has its own enable. A power-down input forces all outputs low and freezes the divider where it stands, so the phase carries on from the same point once power-down is released.

Top module: `clk_divsel`

## Requirements
- R1: With `mode_sel` = 1, each enabled output equals the input clock: high while `clk_in` is high, low while it is low.
- R2: With `mode_sel` = 2 and `div_code` = c (1 to 7), the divided clock has a period of N = c+1 input cycles. It is high for the first ceil(N/2) cycles of each period and low for the rest. It changes only just after rising input edges.
- R3: With `mode_sel` = 2 and `div_code` = 0, the outputs behave as in R1, and `mode_err` stays low.
- R4: In divide mode, while `div_rst` is high at a rising edge, the divided outputs are low after that edge. At the first rising edge where `div_rst` is low again, they go high and then follow the R2 pattern from its start.
- R5: A `sync_pulse` sampled high together with `sync_en` restarts the divider as in R4. With `sync_en` low, the strobe leaves the divided pattern unchanged.
- R6: `div_rst` has no effect in pass-through mode: the outputs keep following the input clock.
- R7: Output i is low whenever `out_en[i]` is 0. The enables act independently, bit i controlling `clk_out[i]`.
- R8: While `pwr_down` is high, all outputs are low and the divider phase is frozen. After release, the divided pattern continues from the cycle where it stopped.
- R9: A `mode_sel` of 0 or 3 sets `mode_err` and holds all outputs low. Modes 1 and 2 clear `mode_err`.
- R10: While `rst_n` is low, the divider state is cleared and the divided outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock, also the divider clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 1 = pass-through, 2 = divide, 0 and 3 = invalid |
| div_code | input | CODE_W | Divide code; ratio is code+1, 0 selects pass-through |
| div_rst | input | 1 | Software divider restart, level sensitive |
| sync_pulse | input | 1 | External sync strobe, one cycle |
| sync_en | input | 1 | Qualifier that lets `sync_pulse` restart the divider |
| out_en | input | N_OUT | Per-output enable |
| pwr_down | input | 1 | Forces outputs low and freezes the divider |
| clk_out | output | N_OUT | Gated clock outputs |
| mode_err | output | 1 | High for an invalid mode value |

## Verification
If the counter's terminal compare is wrong, the high/low run lengths on `clk_out` are wrong within one divided period. Each ratio is therefore checked bit by bit over two full periods. A restart path that fails to clear shows up at the first edge after release: the output is not high at that edge, or it is high while restart is held. A divider that keeps counting through power-down shows up as a phase slip in the very first samples after release. Errors in mode decode or gating show up in a single sample taken during the high phase of the input clock.

// File: rtl/clk_divsel_pkg.sv
package clk_divsel_pkg;

   typedef enum logic [1:0] {
      MODE_RSVD_LO = 2'd0,
      MODE_PASS    = 2'd1,
      MODE_DIVIDE  = 2'd2,
      MODE_RSVD_HI = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_PASS = 2'd1,
      SRC_DIV  = 2'd2
   } src_e;

endpackage

// File: rtl/clk_divsel_decode.sv
module clk_divsel_decode
   import clk_divsel_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic [1:0]        mode_sel,
   input  logic [CODE_W-1:0] div_code,
   output src_e              src,
   output logic              mode_err
);

   always_comb begin
      src      = SRC_OFF;
      mode_err = 1'b0;
      case (mode_e'(mode_sel))
         MODE_PASS:   src = SRC_PASS;
         MODE_DIVIDE: src = (div_code == '0) ? SRC_PASS : SRC_DIV;
         default: begin
            src      = SRC_OFF;
            mode_err = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/clk_divsel_counter.sv
module clk_divsel_counter #(
   parameter int CODE_W = 3
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              freeze,
   input  logic [CODE_W-1:0] div_code,
   output logic              div_q
);

   localparam int RAT_W = CODE_W + 1;

   logic [CODE_W-1:0] cnt;
   logic [RAT_W-1:0]  ratio;
   logic [RAT_W-1:0]  hi_len;
   logic              at_last;
   logic              in_high;
   logic              hold;

   assign ratio   = {1'b0, div_code} + RAT_W'(1);
   assign hi_len  = (ratio + RAT_W'(1)) >> 1;
   assign at_last = (cnt == div_code);
   assign in_high = ({1'b0, cnt} < hi_len);
   assign hold    = ~run | restart;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         div_q <= 1'b0;
      end else if (hold) begin
         cnt   <= '0;
         div_q <= 1'b0;
      end else if (!freeze) begin
         div_q <= in_high;
         cnt   <= at_last ? '0 : cnt + CODE_W'(1);
      end
   end

endmodule

// File: rtl/clk_divsel_gate.sv
module clk_divsel_gate
   import clk_divsel_pkg::*;
#(
   parameter int N_OUT = 4
) (
   input  logic             clk_in,
   input  logic             div_q,
   input  src_e             src,
   input  logic [N_OUT-1:0] out_en,
   input  logic             pwr_down,
   output logic [N_OUT-1:0] clk_out
);

   logic sel_clk;

   always_comb begin
      case (src)
         SRC_PASS: sel_clk = clk_in;
         SRC_DIV:  sel_clk = div_q;
         default:  sel_clk = 1'b0;
      endcase
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign clk_out[i] = sel_clk & out_en[i] & ~pwr_down;
   end

endmodule

// File: rtl/clk_divsel.sv
module clk_divsel
   import clk_divsel_pkg::*;
#(
   parameter int N_OUT  = 4,
   parameter int CODE_W = 3
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic [CODE_W-1:0] div_code,
   input  logic              div_rst,
   input  logic              sync_pulse,
   input  logic              sync_en,
   input  logic [N_OUT-1:0]  out_en,
   input  logic              pwr_down,
   output logic [N_OUT-1:0]  clk_out,
   output logic              mode_err
);

   initial begin
      assert (N_OUT >= 1) else $error("N_OUT must be at least 1");
      assert (CODE_W >= 1 && CODE_W <= 8) else $error("CODE_W must be 1 to 8");
   end

   src_e src;
   logic div_active;
   logic restart;
   logic div_q;

   assign div_active = (src == SRC_DIV);
   assign restart    = div_rst | (sync_en & sync_pulse);

   clk_divsel_decode #(.CODE_W(CODE_W)) u_decode (
      .mode_sel (mode_sel),
      .div_code (div_code),
      .src      (src),
      .mode_err (mode_err)
   );

   clk_divsel_counter #(.CODE_W(CODE_W)) u_counter (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .run      (div_active),
      .restart  (restart),
      .freeze   (pwr_down),
      .div_code (div_code),
      .div_q    (div_q)
   );

   clk_divsel_gate #(.N_OUT(N_OUT)) u_gate (
      .clk_in   (clk_in),
      .div_q    (div_q),
      .src      (src),
      .out_en   (out_en),
      .pwr_down (pwr_down),
      .clk_out  (clk_out)
   );

endmodule

// File: rtl/clk_divsel_chk.sv
module clk_divsel_chk #(
   parameter int N_OUT  = 4,
   parameter int CODE_W = 3
) (
   input logic              clk_in,
   input logic              rst_n,
   input logic [1:0]        mode_sel,
   input logic [CODE_W-1:0] div_code,
   input logic              div_rst,
   input logic              sync_pulse,
   input logic              sync_en,
   input logic [N_OUT-1:0]  out_en,
   input logic              pwr_down,
   input logic [N_OUT-1:0]  clk_out,
   input logic              mode_err,
   input logic              div_q,
   input logic              div_active
);

   logic hold_c;
   assign hold_c = !div_active || div_rst || (sync_en && sync_pulse);

   AST_PASS_FOLLOWS: assert property (@(negedge clk_in) disable iff (!rst_n)
      (mode_sel == 2'd1 && !div_rst && !pwr_down) |-> (clk_out == out_en)); // R1

   AST_CODE0_PASS: assert property (@(negedge clk_in) disable iff (!rst_n)
      (mode_sel == 2'd2 && div_code == '0 && !pwr_down) |-> (clk_out == out_en && !mode_err)); // R3

   AST_RST_HOLDS_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
      (div_active && div_rst) |=> !div_q); // R4

   AST_RELEASE_RISE: assert property (@(posedge clk_in) disable iff (!rst_n)
      (!hold_c && $past(hold_c) && !pwr_down) |=> div_q); // R4

   AST_SYNC_CLEARS: assert property (@(posedge clk_in) disable iff (!rst_n)
      (div_active && sync_en && sync_pulse) |=> !div_q); // R5

   AST_SWRST_IGNORED: assert property (@(negedge clk_in) disable iff (!rst_n)
      (mode_sel == 2'd1 && div_rst && !pwr_down) |-> (clk_out == out_en)); // R6

   AST_EN_GATES: assert property (@(negedge clk_in) disable iff (!rst_n)
      (clk_out & ~out_en) == '0); // R7

   AST_PD_SILENT: assert property (@(negedge clk_in) disable iff (!rst_n)
      pwr_down |-> (clk_out == '0)); // R8

   AST_PD_FROZEN: assert property (@(posedge clk_in) disable iff (!rst_n)
      (pwr_down && !hold_c) |=> $stable(div_q)); // R8

   AST_RSVD_SILENT: assert property (@(negedge clk_in) disable iff (!rst_n)
      mode_err |-> (clk_out == '0 && (mode_sel == 2'd0 || mode_sel == 2'd3))); // R9

endmodule

bind clk_divsel clk_divsel_chk #(.N_OUT(N_OUT), .CODE_W(CODE_W)) u_chk (
   .clk_in     (clk_in),
   .rst_n      (rst_n),
   .mode_sel   (mode_sel),
   .div_code   (div_code),
   .div_rst    (div_rst),
   .sync_pulse (sync_pulse),
   .sync_en    (sync_en),
   .out_en     (out_en),
   .pwr_down   (pwr_down),
   .clk_out    (clk_out),
   .mode_err   (mode_err),
   .div_q      (div_q),
   .div_active (div_active)
);

// File: tb/clk_divsel_test.sv
module clk_divsel_test;

   localparam int N_OUT  = 4;
   localparam int CODE_W = 3;

   logic              clk_in = 1'b0;
   logic              rst_n  = 1'b0;
   logic [1:0]        mode_sel = 2'd1;
   logic [CODE_W-1:0] div_code = 3'd2;
   logic              div_rst = 1'b0;
   logic              sync_pulse = 1'b0;
   logic              sync_en = 1'b0;
   logic [N_OUT-1:0]  out_en = '1;
   logic              pwr_down = 1'b0;
   logic [N_OUT-1:0]  clk_out;
   logic              mode_err;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk_in = ~clk_in;

   clk_divsel #(.N_OUT(N_OUT), .CODE_W(CODE_W)) uut (
      .clk_in(clk_in), .rst_n(rst_n), .mode_sel(mode_sel), .div_code(div_code),
      .div_rst(div_rst), .sync_pulse(sync_pulse), .sync_en(sync_en),
      .out_en(out_en), .pwr_down(pwr_down), .clk_out(clk_out), .mode_err(mode_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hi_step();
      @(posedge clk_in); #5;
   endtask

   task automatic lo_step();
      @(negedge clk_in); #5;
   endtask

   // restart the divider: one held edge, then released
   task automatic restart_div();
      div_rst = 1'b1;
      hi_step();
      div_rst = 1'b0;
   endtask

   task automatic t_reset();
      mode_sel = 2'd2; div_code = 3'd2;
      hi_step(); hi_step();
      check("R10 outputs low in reset", clk_out, 0);
      check("R10 no error in reset", mode_err, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_pass();
      mode_sel = 2'd1; out_en = '1;
      hi_step();
      check("R1 pass high phase", clk_out, 4'hF);
      lo_step();
      check("R1 pass low phase", clk_out, 4'h0);
      check("R9 mode 1 no error", mode_err, 0);
   endtask

   task automatic t_ratio(input int code);
      logic [31:0] act, exp;
      int n, h;
      n = code + 1;
      h = (n + 1) / 2;
      act = '0; exp = '0;
      mode_sel = 2'd2; div_code = CODE_W'(code);
      restart_div();
      for (int k = 0; k < 2 * n; k++) begin
         hi_step();
         act[k] = clk_out[0] & clk_out[3];
         exp[k] = ((k % n) < h);
      end
      check($sformatf("R2 pattern code %0d", code), act, exp);
   endtask

   task automatic t_code0();
      mode_sel = 2'd2; div_code = '0;
      hi_step();
      check("R3 code 0 high phase", clk_out, 4'hF);
      lo_step();
      check("R3 code 0 low phase", clk_out, 4'h0);
      check("R3 code 0 no error", mode_err, 0);
   endtask

   task automatic t_swreset();
      logic [31:0] act;
      mode_sel = 2'd2; div_code = 3'd4; // N=5, high 3
      restart_div();
      hi_step(); hi_step();
      div_rst = 1'b1;
      act = '0;
      for (int k = 0; k < 3; k++) begin
         hi_step();
         act[k] = |clk_out;
      end
      check("R4 low while held", act, 0);
      div_rst = 1'b0;
      act = '0;
      for (int k = 0; k < 5; k++) begin
         hi_step();
         act[k] = clk_out[1];
      end
      check("R4 restart pattern", act, 32'b00111);
   endtask

   task automatic t_sync();
      logic [31:0] act;
      mode_sel = 2'd2; div_code = 3'd2; // N=3: 1,1,0
      restart_div();
      hi_step();                          // k0
      sync_en = 1'b0; sync_pulse = 1'b1;
      act = '0;
      hi_step(); act[0] = clk_out[0];     // k1 = 1
      sync_pulse = 1'b0;
      hi_step(); act[1] = clk_out[0];     // k2 = 0
      check("R5 strobe ignored without qualifier", act, 32'b01);
      hi_step();                          // k3 = 1
      sync_en = 1'b1; sync_pulse = 1'b1;
      act = '0;
      hi_step(); act[0] = clk_out[0];     // held -> 0
      sync_pulse = 1'b0;
      for (int k = 1; k < 4; k++) begin
         hi_step(); act[k] = clk_out[0];
      end
      check("R5 qualified strobe restarts", act, 32'b0110);
      sync_en = 1'b0;
   endtask

   task automatic t_rst_in_pass();
      mode_sel = 2'd1; div_rst = 1'b1;
      hi_step(); hi_step();
      check("R6 div_rst ignored high phase", clk_out, 4'hF);
      lo_step();
      check("R6 div_rst ignored low phase", clk_out, 4'h0);
      div_rst = 1'b0;
   endtask

   task automatic t_enables();
      mode_sel = 2'd1;
      out_en = 4'b0101; hi_step();
      check("R7 enables 0101", clk_out, 4'b0101);
      out_en = 4'b1010; hi_step();
      check("R7 enables 1010", clk_out, 4'b1010);
      out_en = 4'b0000; hi_step();
      check("R7 enables off", clk_out, 4'b0000);
      out_en = 4'b0011; mode_sel = 2'd2; div_code = 3'd1;
      restart_div();
      hi_step();
      check("R7 divided enables 0011", clk_out, 4'b0011);
      out_en = '1;
   endtask

   task automatic t_pd();
      logic [31:0] act;
      mode_sel = 2'd2; div_code = 3'd4; // N=5, high 3
      restart_div();
      hi_step(); hi_step();               // k0, k1 high
      pwr_down = 1'b1;
      act = '0;
      for (int k = 0; k < 3; k++) begin
         hi_step(); act[k] = |clk_out;
      end
      check("R8 low in power-down", act, 0);
      pwr_down = 1'b0;
      act = '0;
      for (int k = 0; k < 4; k++) begin
         hi_step(); act[k] = clk_out[2];   // k2..k5: 1,0,0,1
      end
      check("R8 phase resumes", act, 32'b1001);
      mode_sel = 2'd1; pwr_down = 1'b1;
      hi_step();
      check("R8 pass mode silenced", clk_out, 0);
      pwr_down = 1'b0;
   endtask

   task automatic t_reserved();
      mode_sel = 2'd0; hi_step();
      check("R9 mode 0 outputs", clk_out, 0);
      check("R9 mode 0 flag", mode_err, 1);
      mode_sel = 2'd3; hi_step();
      check("R9 mode 3 outputs", clk_out, 0);
      check("R9 mode 3 flag", mode_err, 1);
      mode_sel = 2'd2; div_code = 3'd3; hi_step();
      check("R9 mode 2 flag", mode_err, 0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_pass();
      t_ratio(1);
      t_ratio(2);
      t_ratio(4);
      t_ratio(7);
      t_code0();
      t_swreset();
      t_sync();
      t_rst_in_pass();
      t_enables();
      t_pd();
      t_reserved();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule